// File: doc/BRIEF.md
# Hysteretic Temperature Fan Supervisor

This block watches a stream of digitised temperature samples and keeps two alarm flags. Each flag has its own pair of thresholds, one to set it and one to clear it. The user-temperature flag covers the lower band and the over-temperature flag covers the upper band. Because each flag clears at a lower value than the one that sets it, a temperature that hovers near a threshold does not make the flag chatter.

From the two flags the block picks one of three fan duty levels and drives a pulse-width-modulated fan output at that level. It also drives a combined alarm output. The sensor and the analog-to-digital converter sit outside the block. It receives a 12-bit unsigned code with a valid strobe. With the default parameters one code step is 1/16 °C, so the default thresholds are 80/60 °C for the upper band and 35/30 °C for the lower band.

Top module: `fan_supervisor`

## Requirements
- R1: A synchronous active-high reset clears both flags and the combined alarm, and the fan output then runs at the low duty (64 high cycles out of every 256) until a sample changes a flag.
- R2: When `temp_vld` is high and `temp_code` is at least 560, the user-temperature flag is set on the next clock.
- R3: When `temp_vld` is high and `temp_code` is at most 480, the user-temperature flag clears on the next clock. A valid sample strictly between 480 and 560 leaves the flag unchanged.
- R4: The over-temperature flag sets on a valid sample of at least 1280 and clears on a valid sample of at most 960. A valid sample strictly between those values leaves it unchanged.
- R5: Samples presented while `temp_vld` is low have no effect on either flag, whatever their value.
- R6: `any_alarm` is high exactly when at least one of `user_alarm` and `over_alarm` is high.
- R7: The duty is 64/256 while neither flag is set, 160/256 while only the user-temperature flag is set, and 255/256 while the over-temperature flag is set.
- R8: The fan output repeats with a period of 256 clocks. Each period begins with the output rising, and its high time is a single contiguous run from the start of the period. A change of selected duty takes effect only at the next period start, so the period already under way keeps its old high time.
- R9: A temperature that rises through 35 °C and 80 °C and then falls back through 60 °C and 30 °C produces the duty sequence low, medium, high, medium, low. Each step is taken at the set or clear threshold of the band concerned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| temp_vld | input | 1 | Qualifies `temp_code` for one cycle |
| temp_code | input | 12 | Unsigned temperature code, 1/16 °C per step by default |
| user_alarm | output | 1 | Lower-band (user-temperature) flag |
| over_alarm | output | 1 | Upper-band (over-temperature) flag |
| any_alarm | output | 1 | OR of the two flags |
| fan_pwm | output | 1 | Fan drive, high while the period counter is below the active duty |

## Verification
The hardest case to reach from the ports is a flag change that lands in the middle of a PWM period. In that case the high time of the running period must still match the old level, and the new level must appear only in the following period. The period counter is internal, so the bench locks onto the rising edge of `fan_pwm`, which marks every period start. It then applies a qualifying sample a fixed number of cycles into the high phase and measures the high time of that period and of the next one separately. The hysteresis bands are walked one code on either side of each threshold, so that the hold region and both comparison edges are each exercised.

// File: rtl/fan_sup_pkg.sv
package fan_sup_pkg;
    // Fan duty level chosen from the alarm flags.
    typedef enum logic [1:0] {
        LVL_LOW  = 2'd0,
        LVL_MID  = 2'd1,
        LVL_HIGH = 2'd2
    } fan_level_e;
endpackage

// File: rtl/hyst_flag.sv
// One hysteresis comparator: a flag with separate set and clear thresholds.
module hyst_flag #(
    parameter int          W      = 12,
    parameter int unsigned SET_TH = 560,
    parameter int unsigned CLR_TH = 480
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sample_vld,
    input  logic [W-1:0] sample,
    output logic         flag
);
    localparam logic [W-1:0] SET_C = SET_TH[W-1:0];
    localparam logic [W-1:0] CLR_C = CLR_TH[W-1:0];

    typedef struct packed {
        logic flag;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sample_vld) begin
            if (sample >= SET_C)
                st_d.flag = 1'b1;
            else if (sample <= CLR_C)
                st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign flag = st_q.flag;

    // R2 R4
    set_at_thresh_chk: assert property (@(posedge clk) disable iff (rst)
        (sample_vld && sample >= SET_C) |=> flag);

    // R3 R4
    clear_at_thresh_chk: assert property (@(posedge clk) disable iff (rst)
        (sample_vld && sample <= CLR_C && sample < SET_C) |=> !flag);

    // R5
    hold_without_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !sample_vld |=> $stable(flag));
endmodule

// File: rtl/fan_pwm_gen.sv
// Free-running PWM whose duty is latched only at the start of each period.
module fan_pwm_gen
    import fan_sup_pkg::*;
#(
    parameter int          CNT_W    = 8,
    parameter int unsigned DUTY_LOW  = 64,
    parameter int unsigned DUTY_MID  = 160,
    parameter int unsigned DUTY_HIGH = 255
) (
    input  logic       clk,
    input  logic       rst,
    input  fan_level_e level,
    output logic       pwm
);
    localparam logic [CNT_W-1:0] D_LOW  = DUTY_LOW[CNT_W-1:0];
    localparam logic [CNT_W-1:0] D_MID  = DUTY_MID[CNT_W-1:0];
    localparam logic [CNT_W-1:0] D_HIGH = DUTY_HIGH[CNT_W-1:0];
    localparam logic [CNT_W-1:0] CNT_LAST = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] duty;
    } state_t;

    state_t st_d, st_q;
    logic [CNT_W-1:0] duty_sel;

    always_comb begin
        unique case (level)
            LVL_HIGH: duty_sel = D_HIGH;
            LVL_MID:  duty_sel = D_MID;
            default:  duty_sel = D_LOW;
        endcase
    end

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + 1'b1;
        if (st_q.cnt == CNT_LAST)
            st_d.duty = duty_sel;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cnt  <= '0;
            st_q.duty <= D_LOW;
        end else begin
            st_q <= st_d;
        end
    end

    assign pwm = (st_q.cnt < st_q.duty);

    // R8
    duty_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.cnt != CNT_LAST) |=> $stable(st_q.duty));

    // R8
    period_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.cnt == CNT_LAST) |=> (st_q.cnt == '0));
endmodule

// File: rtl/fan_supervisor.sv
module fan_supervisor
    import fan_sup_pkg::*;
#(
    parameter int          TEMP_W    = 12,
    parameter int          CNT_W     = 8,
    parameter int unsigned USER_SET  = 560,
    parameter int unsigned USER_CLR  = 480,
    parameter int unsigned OVER_SET  = 1280,
    parameter int unsigned OVER_CLR  = 960,
    parameter int unsigned DUTY_LOW  = 64,
    parameter int unsigned DUTY_MID  = 160,
    parameter int unsigned DUTY_HIGH = 255
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              temp_vld,
    input  logic [TEMP_W-1:0] temp_code,
    output logic              user_alarm,
    output logic              over_alarm,
    output logic              any_alarm,
    output logic              fan_pwm
);
    logic       user_q, over_q;
    fan_level_e level_d;

    hyst_flag #(.W(TEMP_W), .SET_TH(USER_SET), .CLR_TH(USER_CLR)) u_user (
        .clk(clk), .rst(rst), .sample_vld(temp_vld), .sample(temp_code), .flag(user_q)
    );

    hyst_flag #(.W(TEMP_W), .SET_TH(OVER_SET), .CLR_TH(OVER_CLR)) u_over (
        .clk(clk), .rst(rst), .sample_vld(temp_vld), .sample(temp_code), .flag(over_q)
    );

    // Upper band dominates; lower band alone gives the middle level.
    always_comb begin
        if (over_q)      level_d = LVL_HIGH;
        else if (user_q) level_d = LVL_MID;
        else             level_d = LVL_LOW;
    end

    fan_pwm_gen #(
        .CNT_W(CNT_W), .DUTY_LOW(DUTY_LOW), .DUTY_MID(DUTY_MID), .DUTY_HIGH(DUTY_HIGH)
    ) u_pwm (
        .clk(clk), .rst(rst), .level(level_d), .pwm(fan_pwm)
    );

    assign user_alarm = user_q;
    assign over_alarm = over_q;
    assign any_alarm  = user_q | over_q;

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!user_alarm && !over_alarm));

    // R4 R2: an upper-band setting sample always sets the lower band too
    over_implies_user_set_chk: assert property (@(posedge clk) disable iff (rst)
        (temp_vld && temp_code >= OVER_SET[TEMP_W-1:0]) |=> (user_alarm && over_alarm));
endmodule

// File: tb/fan_supervisor_test.sv
`timescale 1ns/1ps
module fan_supervisor_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        temp_vld = 1'b0;
    logic [11:0] temp_code = '0;
    logic        user_alarm, over_alarm, any_alarm, fan_pwm;

    int nchk = 0;
    int nerr = 0;
    bit exp_u = 1'b0;
    bit exp_o = 1'b0;

    always #10 clk = ~clk;

    fan_supervisor uut (
        .clk(clk), .rst(rst), .temp_vld(temp_vld), .temp_code(temp_code),
        .user_alarm(user_alarm), .over_alarm(over_alarm),
        .any_alarm(any_alarm), .fan_pwm(fan_pwm)
    );

    task automatic chk(string req, int act, int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_duty();
        if (exp_o) return 255;
        if (exp_u) return 160;
        return 64;
    endfunction

    task automatic send(int t);
        @(negedge clk);
        temp_code = t[11:0];
        temp_vld  = 1'b1;
        @(negedge clk);
        temp_vld  = 1'b0;
        if (t >= 560) exp_u = 1'b1; else if (t <= 480) exp_u = 1'b0;
        if (t >= 1280) exp_o = 1'b1; else if (t <= 960) exp_o = 1'b0;
    endtask

    task automatic chk_flags(string req);
        chk({req, " user"}, int'(user_alarm), int'(exp_u));
        chk({req, " over"}, int'(over_alarm), int'(exp_o));
    endtask

    // Wait until the negedge where fan_pwm has just risen (period start).
    task automatic align();
        logic prev;
        prev = fan_pwm;
        forever begin
            @(negedge clk);
            if (!prev && fan_pwm) break;
            prev = fan_pwm;
        end
    endtask

    // From a period start, count high cycles over one period.
    task automatic period_highs(output int h);
        h = 0;
        for (int i = 0; i < 256; i++) begin
            if (fan_pwm) h++;
            @(negedge clk);
        end
    endtask

    task automatic chk_duty(string req, int exp);
        int h;
        align();
        period_highs(h);
        chk(req, h, exp);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 user after reset", int'(user_alarm), 0);
        chk("R1 over after reset", int'(over_alarm), 0);
        chk("R1 any after reset", int'(any_alarm), 0);
        rst = 1'b0;
        exp_u = 1'b0; exp_o = 1'b0;
        chk_duty("R1 duty after reset", 64);
    endtask

    task automatic t_user_band();
        send(559); chk_flags("R2 below set");
        send(560); chk_flags("R2 at set");
        chk("R2 user set", int'(user_alarm), 1);
        send(500); chk_flags("R3 hold 500");
        send(481); chk_flags("R3 hold 481");
        chk("R3 still set", int'(user_alarm), 1);
        send(480); chk_flags("R3 at clear");
        chk("R3 cleared", int'(user_alarm), 0);
        send(559); chk_flags("R3 hold low 559");
    endtask

    task automatic t_over_band();
        send(1279); chk_flags("R4 below set");
        chk("R4 not set 1279", int'(over_alarm), 0);
        send(1280); chk_flags("R4 at set");
        chk("R4 set", int'(over_alarm), 1);
        send(961); chk_flags("R4 hold 961");
        send(960); chk_flags("R4 at clear");
        chk("R4 cleared", int'(over_alarm), 0);
        send(1279); chk_flags("R4 hold low 1279");
        send(0); chk_flags("R4 cool");
    endtask

    task automatic t_ignore();
        @(negedge clk);
        temp_code = 12'd4000;
        repeat (6) @(negedge clk);
        chk_flags("R5 hot ignored");
        send(1500);
        @(negedge clk);
        temp_code = 12'd0;
        repeat (6) @(negedge clk);
        chk_flags("R5 cold ignored");
        chk("R5 over kept", int'(over_alarm), 1);
        send(0);
    endtask

    task automatic t_alarm_or();
        send(0);   chk("R6 none", int'(any_alarm), 0);
        send(700); chk("R6 user only", int'(any_alarm), 1);
        send(1400); chk("R6 both", int'(any_alarm), 1);
        send(0);   chk("R6 cleared", int'(any_alarm), 0);
    endtask

    task automatic t_duty_levels();
        send(0);    chk_duty("R7 low", 64);
        send(600);  chk_duty("R7 mid", 160);
        send(2000); chk_duty("R7 high", 255);
        send(0);    chk_duty("R7 back low", 64);
    endtask

    task automatic t_midperiod();
        int h, p;
        send(0);
        chk_duty("R8 settle low", 64);
        align();
        h = 0;
        for (int i = 0; i < 256; i++) begin
            if (fan_pwm) h++;
            if (i == 20) begin temp_code = 12'd700; temp_vld = 1'b1; end
            if (i == 21) temp_vld = 1'b0;
            @(negedge clk);
        end
        exp_u = 1'b1;
        chk("R8 running period keeps old duty", h, 64);
        chk("R8 new period starts high", int'(fan_pwm), 1);
        period_highs(h);
        chk("R8 next period new duty", h, 160);
        p = 0;
        align();
        do begin p++; @(negedge clk); end while (!(fan_pwm && p > 1 && h == 160 && p >= 256));
        chk("R8 period length", p, 256);
        send(0);
    endtask

    task automatic t_profile();
        int temps[8] = '{400, 560, 900, 1280, 1100, 960, 700, 480};
        foreach (temps[k]) begin
            send(temps[k]);
            chk_duty($sformatf("R9 profile step %0d (code %0d)", k, temps[k]), exp_duty());
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        nchk++; nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_user_band();
        t_over_band();
        t_ignore();
        t_alarm_or();
        t_duty_levels();
        t_midperiod();
        t_profile();
        finish_run();
    end
endmodule